// File: doc/BRIEF.md
# I2C Target Command Frame Handler

This block sits behind a byte-level I2C target engine and turns bus traffic into host commands. A host writes a request frame to the block's bus address. The block stores the frame, works out its header and checks the frame's checksum. When the host next reads from the same address, the block offers the stored command to a local executor through a valid/ready handshake. The executor reads the parameters through a random-access port. The block then accepts a response (a result code and a payload) through a second handshake and sends it out byte by byte.

Two request layouts are recognised. A first byte at or above a version base opens a framed request: version offset, command, length, parameters, then an 8-bit additive checksum. A first byte below that base is an unframed legacy command, whose reply is also sent in legacy form. Any read byte that has no response behind it is answered with the filler 0xEC.

Top module: `i2c_cmd_target`

## Requirements
- R1: The block reacts only to address strobes carrying the 7-bit address TARGET_ADDR (default 0x1E, 0x3C in 8-bit form). `addr_hit` is high only during such a strobe. Bytes written after a strobe to any other address leave no pending command.
- R2: A frame whose byte 0 is at least VBASE (default 0xDA) is framed: `cmd_ver` = byte0 - VBASE, `cmd_code` = byte1, `cmd_len` = byte2, and parameter index k reads frame byte 3+k, `cmd_legacy` = 0.
- R3: In a framed request the byte at position 3+len must equal the low 8 bits of the sum of bytes 0..2+len. Otherwise, or when that byte is missing, `cmd_csum_bad` is 1 and the first response byte is RES_BAD_SUM (default 0x08) instead of `rsp_result`.
- R4: A frame whose byte 0 is below VBASE is legacy: `cmd_legacy` = 1, `cmd_ver` = 0, `cmd_code` = byte0, `cmd_len` = PRM_DEPTH (default 252), and parameter index k reads frame byte 1+k.
- R5: A framed response is sent as: result, payload length, the payload bytes, then the low 8 bits of the sum of result, length and payload.
- R6: A legacy response is sent as: result, payload bytes, then the low 8 bits of the sum of the payload bytes only, with no length byte.
- R7: A read with no pending command raises no `cmd_valid` and returns 0xEC on every byte.
- R8: A stop after a write of at least one byte makes the command pending. The next addressed read raises `cmd_valid`, which holds until `cmd_ready`. The handshake clears the pending state, so the read after that gets only filler.
- R9: A master NACK ends the response: every later byte of that read is 0xEC, and the next write/read exchange works normally.
- R10: When a write carries more than PRM_DEPTH+4 bytes, the extra bytes are dropped and the frame reports `cmd_csum_bad` = 1 with result byte RES_BAD_SUM.
- R11: After dispatch, every byte requested before the `rsp_valid`/`rsp_ready` handshake is 0xEC. The response starts at the next byte request after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_stb | input | 1 | Address phase complete strobe |
| bus_addr | input | 7 | 7-bit address seen on the bus |
| bus_rd | input | 1 | Direction of the addressed transfer, 1 = master read |
| addr_hit | output | 1 | Address strobe matches TARGET_ADDR |
| rx_stb | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| tx_req | input | 1 | Engine consumes `tx_data` for the next bus byte |
| tx_data | output | 8 | Byte to transmit on the next request |
| stop_stb | input | 1 | Stop condition detected |
| nack_stb | input | 1 | Master did not acknowledge the last byte |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_code | output | 8 | Command opcode |
| cmd_ver | output | 8 | Command version |
| cmd_len | output | 8 | Parameter length |
| cmd_legacy | output | 1 | Request was in legacy layout |
| cmd_csum_bad | output | 1 | Checksum mismatch or overflow |
| prm_idx | input | 8 | Parameter byte index |
| prm_data | output | 8 | Parameter byte at `prm_idx` |
| rsp_valid | input | 1 | Response fields are valid |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_result | input | 8 | Result code |
| rsp_len | input | 8 | Payload length |
| pay_idx | output | 8 | Payload byte index being sent |
| pay_data | input | 8 | Payload byte at `pay_idx` |

## Verification
Framed requests are generated at random, with random lengths, versions and opcodes, and each has either a correct or a corrupted checksum. Comparing the reply's first byte against the result or the error code separates a correct checksum check from one that is always true. Random legacy requests follow the other path: a missing length byte and a payload-only checksum in the reply separate the two layouts. Directed cases cover a wrong address, a read with nothing pending, a repeated read after dispatch, a NACK mid-response, an over-long write, padding before the response arrives, and zero-length payloads in both layouts.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam logic [7:0] FILL_BYTE = 8'hEC;

    typedef enum logic [2:0] {
        C_IDLE,
        C_RX,
        C_DISP,
        C_WAITR,
        C_SEND
    } ctl_state_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_RES,
        T_LEN,
        T_PAY,
        T_SUM
    } tx_phase_e;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] ver;
        logic [7:0] len;
        logic       legacy;
        logic       bad;
    } cmd_hdr_t;

    function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/i2c_cmd_rxframe.sv
module i2c_cmd_rxframe
    import i2c_cmd_pkg::*;
#(
    parameter logic [7:0] VBASE     = 8'hDA,
    parameter int         PRM_DEPTH = 252,
    parameter int         PIW       = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           rx_en,
    input  logic [7:0]     rx_byte,
    input  logic [PIW-1:0] prm_idx,
    output logic [7:0]     prm_data,
    output cmd_hdr_t       hdr,
    output logic           has_data
);
    localparam int FRM_DEPTH = PRM_DEPTH + 4;
    localparam int AW        = $clog2(FRM_DEPTH);
    localparam int CW        = $clog2(FRM_DEPTH + 1) + 1;

    logic [7:0]    mem [FRM_DEPTH];
    logic [CW-1:0] cnt;
    logic [7:0]    b0, b1, blen, sum;
    logic          seen, ok, ovf;
    logic          is_new;
    logic [CW-1:0] sum_end, rd_idx;

    assign is_new  = (b0 >= VBASE);
    assign sum_end = CW'(blen) + CW'(3);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            b0   <= '0;
            b1   <= '0;
            blen <= '0;
            sum  <= '0;
            seen <= 1'b0;
            ok   <= 1'b0;
            ovf  <= 1'b0;
        end else if (rx_en) begin
            if (cnt < CW'(FRM_DEPTH)) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(0)) b0   <= rx_byte;
                if (cnt == CW'(1)) b1   <= rx_byte;
                if (cnt == CW'(2)) blen <= rx_byte;
                if (cnt < CW'(3) || cnt < sum_end) begin
                    sum <= add8(sum, rx_byte);
                end else if (cnt == sum_end && !seen) begin
                    seen <= 1'b1;
                    ok   <= (rx_byte == sum);
                end
            end else begin
                ovf <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rx_en && cnt < CW'(FRM_DEPTH)) mem[cnt[AW-1:0]] <= rx_byte;
    end

    assign rd_idx   = CW'(prm_idx) + (is_new ? CW'(3) : CW'(1));
    assign prm_data = (rd_idx < CW'(FRM_DEPTH)) ? mem[rd_idx[AW-1:0]] : 8'h00;

    always_comb begin
        hdr.legacy = !is_new;
        hdr.code   = is_new ? b1 : b0;
        hdr.ver    = is_new ? (b0 - VBASE) : 8'h00;
        hdr.len    = is_new ? blen : 8'(PRM_DEPTH);
        hdr.bad    = ovf || (is_new && !(seen && ok));
    end

    assign has_data = (cnt != '0);

    // R10: a byte arriving on a full buffer marks the frame bad
    p_full_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !clr && cnt == CW'(FRM_DEPTH)) |=> hdr.bad);

    // R3: once the checksum position is reached in a framed request, the count stays consistent
    p_seen_after_len_r3: assert property (@(posedge clk) disable iff (rst)
        (seen && !clr) |-> (cnt > sum_end));

endmodule

// File: rtl/i2c_cmd_txframe.sv
module i2c_cmd_txframe
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] result,
    input  logic [7:0] len,
    input  logic       legacy,
    input  logic       tx_req,
    input  logic [7:0] pay_data,
    output logic [7:0] tx_data,
    output logic [7:0] pay_idx,
    output logic       active
);
    tx_phase_e  phase;
    logic [7:0] pcnt, sum, res_q, len_q;
    logic       leg_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase <= T_IDLE;
            pcnt  <= '0;
            sum   <= '0;
            res_q <= '0;
            len_q <= '0;
            leg_q <= 1'b0;
        end else if (start) begin
            phase <= T_RES;
            pcnt  <= '0;
            sum   <= '0;
            res_q <= result;
            len_q <= len;
            leg_q <= legacy;
        end else if (tx_req) begin
            unique case (phase)
                T_RES: begin
                    sum <= leg_q ? 8'h00 : res_q;
                    if (!leg_q)             phase <= T_LEN;
                    else if (len_q == 8'd0) phase <= T_SUM;
                    else                    phase <= T_PAY;
                end
                T_LEN: begin
                    sum   <= add8(sum, len_q);
                    phase <= (len_q == 8'd0) ? T_SUM : T_PAY;
                end
                T_PAY: begin
                    sum  <= add8(sum, pay_data);
                    pcnt <= pcnt + 8'd1;
                    if (pcnt == len_q - 8'd1) phase <= T_SUM;
                end
                T_SUM:   phase <= T_IDLE;
                default: phase <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            T_RES:   tx_data = res_q;
            T_LEN:   tx_data = len_q;
            T_PAY:   tx_data = pay_data;
            T_SUM:   tx_data = sum;
            default: tx_data = FILL_BYTE;
        endcase
    end

    assign pay_idx = pcnt;
    assign active  = (phase != T_IDLE);

    // R6: a legacy response never emits a length byte
    p_no_len_legacy_r6: assert property (@(posedge clk) disable iff (rst)
        leg_q |-> (phase != T_LEN));

    // R5: payload index stays inside the announced length
    p_pay_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == T_PAY) |-> (pcnt < len_q));

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h1E,
    parameter logic [7:0] VBASE       = 8'hDA,
    parameter logic [7:0] RES_BAD_SUM = 8'h08,
    parameter int         PRM_DEPTH   = 252,
    parameter int         PIW         = $clog2(PRM_DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_addr_stb,
    input  logic [6:0]     bus_addr,
    input  logic           bus_rd,
    output logic           addr_hit,
    input  logic           rx_stb,
    input  logic [7:0]     rx_data,
    input  logic           tx_req,
    output logic [7:0]     tx_data,
    input  logic           stop_stb,
    input  logic           nack_stb,
    output logic           cmd_valid,
    input  logic           cmd_ready,
    output logic [7:0]     cmd_code,
    output logic [7:0]     cmd_ver,
    output logic [7:0]     cmd_len,
    output logic           cmd_legacy,
    output logic           cmd_csum_bad,
    input  logic [PIW-1:0] prm_idx,
    output logic [7:0]     prm_data,
    input  logic           rsp_valid,
    output logic           rsp_ready,
    input  logic [7:0]     rsp_result,
    input  logic [7:0]     rsp_len,
    output logic [7:0]     pay_idx,
    input  logic [7:0]     pay_data
);
    ctl_state_e state;
    logic       pending;
    cmd_hdr_t   hdr;
    logic       has_data, rx_clr, rx_en, tx_start, tx_abort, tx_active;
    logic       addr_miss;

    assign addr_hit  = bus_addr_stb && (bus_addr == TARGET_ADDR);
    assign addr_miss = bus_addr_stb && (bus_addr != TARGET_ADDR);
    assign rx_clr    = addr_hit && !bus_rd;
    assign rx_en     = rx_stb && (state == C_RX);
    assign cmd_valid = (state == C_DISP);
    assign rsp_ready = (state == C_WAITR);
    assign tx_start  = rsp_valid && rsp_ready && !stop_stb;
    assign tx_abort  = stop_stb || nack_stb || bus_addr_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= C_IDLE;
            pending <= 1'b0;
        end else if (stop_stb) begin
            if (state == C_RX) pending <= has_data;
            state <= C_IDLE;
        end else if (addr_miss) begin
            state <= C_IDLE;
        end else if (addr_hit) begin
            if (!bus_rd) begin
                state   <= C_RX;
                pending <= 1'b0;
            end else begin
                state <= pending ? C_DISP : C_IDLE;
            end
        end else begin
            unique case (state)
                C_DISP:  if (cmd_ready) begin
                             pending <= 1'b0;
                             state   <= C_WAITR;
                         end
                C_WAITR: if (rsp_valid) state <= C_SEND;
                C_SEND:  if (nack_stb) state <= C_IDLE;
                default: ;
            endcase
        end
    end

    i2c_cmd_rxframe #(
        .VBASE     (VBASE),
        .PRM_DEPTH (PRM_DEPTH),
        .PIW       (PIW)
    ) i_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (rx_clr),
        .rx_en    (rx_en),
        .rx_byte  (rx_data),
        .prm_idx  (prm_idx),
        .prm_data (prm_data),
        .hdr      (hdr),
        .has_data (has_data)
    );

    i2c_cmd_txframe i_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (tx_start),
        .abort    (tx_abort),
        .result   (hdr.bad ? RES_BAD_SUM : rsp_result),
        .len      (rsp_len),
        .legacy   (hdr.legacy),
        .tx_req   (tx_req && state == C_SEND),
        .pay_data (pay_data),
        .tx_data  (tx_data),
        .pay_idx  (pay_idx),
        .active   (tx_active)
    );

    assign cmd_code     = hdr.code;
    assign cmd_ver      = hdr.ver;
    assign cmd_len      = hdr.len;
    assign cmd_legacy   = hdr.legacy;
    assign cmd_csum_bad = hdr.bad;

    // R8: a command only becomes pending on a stop
    p_pend_on_stop_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(stop_stb));

    // R8: an offered command is held until accepted
    p_hold_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !stop_stb && !bus_addr_stb) |=> cmd_valid);

    // R7: a read with nothing pending is never dispatched
    p_no_disp_r7: assert property (@(posedge clk) disable iff (rst)
        (addr_hit && bus_rd && !pending && !stop_stb) |=> !cmd_valid);

    // R11: serialisation only runs after the response handshake
    p_tx_after_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> $past(rsp_valid && rsp_ready));

endmodule

// File: tb/test_i2c_cmd_target.sv
module test_i2c_cmd_target;
    localparam logic [7:0] VB  = 8'hDA;
    localparam logic [7:0] BAD = 8'h08;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       bus_addr_stb = 0, bus_rd = 0, rx_stb = 0, tx_req = 0;
    logic       stop_stb = 0, nack_stb = 0, cmd_ready = 0, rsp_valid = 0;
    logic [6:0] bus_addr = 0;
    logic [7:0] rx_data = 0, rsp_result = 0, rsp_len = 0, prm_idx = 0;
    logic       addr_hit, cmd_valid, cmd_legacy, cmd_csum_bad, rsp_ready;
    logic [7:0] tx_data, cmd_code, cmd_ver, cmd_len, prm_data, pay_idx, pay_data;
    logic [7:0] pay_mem [16];

    assign pay_data = pay_mem[pay_idx[3:0]];

    i2c_cmd_target i_i2c_cmd_target (.*);

    int checks = 0, errors = 0;
    logic [7:0] fr [300];
    int flen;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic addr(input logic [6:0] a, input bit rd);
        bus_addr = a; bus_rd = rd; bus_addr_stb = 1;
        #1 chk(addr_hit == (a == 7'h1E), "R1 addr_hit", addr_hit, a == 7'h1E);
        tick(); bus_addr_stb = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        rx_data = b; rx_stb = 1; tick(); rx_stb = 0;
    endtask

    task automatic stop(); stop_stb = 1; tick(); stop_stb = 0; endtask

    task automatic rd(output logic [7:0] b);
        b = tx_data; tx_req = 1; tick(); tx_req = 0;
    endtask

    task automatic send_frame(input logic [6:0] a);
        addr(a, 0);
        for (int i = 0; i < flen; i++) wr(fr[i]);
        stop();
    endtask

    function automatic logic [7:0] sum_of(input int n);
        logic [7:0] s = 0;
        for (int i = 0; i < n; i++) s += fr[i];
        return s;
    endfunction

    // Full read: dispatch, parameter check, padding, response
    task automatic read_cmd(input bit legacy, input bit bad, input int plen, input string tag);
        logic [7:0] b, s;
        int np;
        addr(7'h1E, 1);
        chk(cmd_valid == 1, {tag, " R8 cmd_valid"}, cmd_valid, 1);
        chk(cmd_legacy == legacy, {tag, " R2/R4 legacy"}, cmd_legacy, legacy);
        chk(cmd_csum_bad == bad, {tag, " R3 csum_bad"}, cmd_csum_bad, bad);
        if (!legacy) begin
            chk(cmd_ver == fr[0] - VB, "R2 ver", cmd_ver, fr[0] - VB);
            chk(cmd_code == fr[1], "R2 code", cmd_code, fr[1]);
            chk(cmd_len == fr[2], "R2 len", cmd_len, fr[2]);
        end else begin
            chk(cmd_ver == 0, "R4 ver", cmd_ver, 0);
            chk(cmd_code == fr[0], "R4 code", cmd_code, fr[0]);
            chk(cmd_len == 8'd252, "R4 len", cmd_len, 252);
        end
        np = legacy ? flen - 1 : int'(fr[2]);
        if (np > 8) np = 8;
        for (int k = 0; k < np; k++) begin
            prm_idx = 8'(k);
            #1 chk(prm_data == fr[(legacy ? 1 : 3) + k], "R2/R4 param", prm_data, fr[(legacy ? 1 : 3) + k]);
        end
        tick(); // hold cmd_valid one cycle without ready
        chk(cmd_valid == 1, "R8 hold", cmd_valid, 1);
        cmd_ready = 1; tick(); cmd_ready = 0;
        for (int k = 0; k < 2; k++) begin
            rd(b);
            chk(b == 8'hEC, "R11 pad", b, 8'hEC);
        end
        chk(rsp_ready == 1, "R11 rsp_ready", rsp_ready, 1);
        rsp_result = 8'($urandom_range(0, 255));
        rsp_len = 8'(plen);
        for (int k = 0; k < 16; k++) pay_mem[k] = 8'($urandom_range(0, 255));
        rsp_valid = 1; tick(); rsp_valid = 0;
        rd(b);
        chk(b == (bad ? BAD : rsp_result), {tag, " R3/R5 result"}, b, bad ? BAD : rsp_result);
        s = legacy ? 8'h0 : b;
        if (!legacy) begin
            rd(b);
            chk(b == rsp_len, "R5 len byte", b, rsp_len);
            s += b;
        end
        for (int k = 0; k < plen; k++) begin
            rd(b);
            chk(b == pay_mem[k], "R5/R6 payload", b, pay_mem[k]);
            s += pay_mem[k];
        end
        rd(b);
        chk(b == s, legacy ? "R6 checksum" : "R5 checksum", b, s);
        rd(b);
        chk(b == 8'hEC, "R7 after response", b, 8'hEC);
        nack_stb = 1; tick(); nack_stb = 0;
        stop();
    endtask

    task automatic read_empty(input string tag);
        logic [7:0] b;
        addr(7'h1E, 1);
        chk(cmd_valid == 0, {tag, " no cmd_valid"}, cmd_valid, 0);
        for (int k = 0; k < 3; k++) begin
            rd(b);
            chk(b == 8'hEC, {tag, " filler"}, b, 8'hEC);
        end
        stop();
    endtask

    task automatic make_new(input int plen, input bit corrupt);
        fr[0] = VB + 8'($urandom_range(0, 3));
        fr[1] = 8'($urandom_range(0, 255));
        fr[2] = 8'(plen);
        for (int i = 0; i < plen; i++) fr[3 + i] = 8'($urandom_range(0, 255));
        fr[3 + plen] = sum_of(3 + plen) + (corrupt ? 8'($urandom_range(1, 255)) : 8'h0);
        flen = 4 + plen;
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd1234));
        tick(); tick(); rst = 0; tick();
        chk(cmd_valid == 0 && rsp_ready == 0, "reset idle", cmd_valid, 0);
        chk(tx_data == 8'hEC, "R7 reset filler", tx_data, 8'hEC);

        read_empty("R7 empty");

        // R1: frame to a foreign address leaves nothing pending
        make_new(2, 0);
        send_frame(7'h1F);
        read_empty("R1 foreign");

        // Zero-length payloads in both layouts
        make_new(0, 0);
        send_frame(7'h1E);
        read_cmd(0, 0, 0, "new len0");
        fr[0] = 8'h05; flen = 1;
        send_frame(7'h1E);
        read_cmd(1, 0, 0, "legacy len0");

        // R8: second read after dispatch gets filler only
        read_empty("R8 repeat");

        // Random mix
        for (int it = 0; it < 20; it++) begin
            bit leg = ($urandom_range(0, 3) == 0);
            bit cor = ($urandom_range(0, 1) == 1);
            int pl  = $urandom_range(0, 8);
            if (leg) begin
                fr[0] = 8'($urandom_range(0, VB - 1));
                flen = $urandom_range(1, 6);
                for (int i = 1; i < flen; i++) fr[i] = 8'($urandom_range(0, 255));
                send_frame(7'h1E);
                read_cmd(1, 0, pl, "R4/R6 rand");
            end else begin
                make_new($urandom_range(0, 8), cor);
                send_frame(7'h1E);
                read_cmd(0, cor, pl, "R2/R3 rand");
            end
        end

        // R3: checksum byte missing
        make_new(3, 0);
        flen = 6;
        send_frame(7'h1E);
        read_cmd(0, 1, 1, "R3 short");

        // R9: NACK mid-response
        make_new(1, 0);
        send_frame(7'h1E);
        addr(7'h1E, 1);
        cmd_ready = 1; tick(); cmd_ready = 0;
        rsp_result = 8'h00; rsp_len = 8'd4;
        rsp_valid = 1; tick(); rsp_valid = 0;
        rd(b);
        chk(b == 8'h00, "R9 first byte", b, 0);
        nack_stb = 1; tick(); nack_stb = 0;
        rd(b);
        chk(b == 8'hEC, "R9 after nack", b, 8'hEC);
        stop();
        make_new(2, 0);
        send_frame(7'h1E);
        read_cmd(0, 0, 2, "R9 recover");

        // R10: over-long write with an otherwise valid checksum
        make_new(2, 0);
        for (int i = 6; i < 262; i++) fr[i] = 8'($urandom_range(0, 255));
        flen = 262;
        send_frame(7'h1E);
        read_cmd(0, 1, 1, "R10 overflow");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule